// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block answers a serial EEPROM command set on four SPI wires (active-low select, serial clock, data in and data out) and keeps a byte-wide memory array in internal flip-flops. It handles sequential reads, status reads, write enable and disable, status writes that set the block-protect level, and byte or page writes that are gathered in a page buffer and committed when select is released. A write-enable latch guards every change. A plain cycle counter stands in for the programming time.

All SPI pins pass through a two-stage synchronizer into the system clock domain, so the system clock must run several times faster than the serial clock. Inputs are taken on the rising serial clock edge and data out changes on the falling edge. Both clock polarities work (SPI mode 0 and mode 3). The array holds 2^ADDR_W bytes. A 16-bit address is always sent on the wire and the bits above ADDR_W are ignored, so ADDR_W = 13 gives the 8K x 8 arrangement. The pad driver uses `so_oe_o` to put serial out into high impedance.

Top module: `eep_spi_slave`

## Requirements
- R1: After reset the array holds FFh in every byte, the status byte reads 00h and `so_oe_o` is low.
- R2: READ (opcode 03h), then a 16-bit address whose upper 16-ADDR_W bits are ignored, returns the addressed byte MSB first. The pointer advances by one per byte and wraps from the top address to 0 for as long as clocks continue.
- R3: `so_oe_o` is high only while read data or status is being shifted out, and is low whenever select is high.
- R4: RDSR (05h) returns the status byte {0000, bp[1:0], wel, busy} (bit0 busy, bit1 write-enable latch, bits 3:2 protect level). It repeats for every further byte and can be read while busy.
- R5: WREN (06h) sets the write-enable latch only when select rises directly after its eighth bit. Any further clock in the same select period cancels it, so a write sent in that period leaves the array unchanged.
- R6: WRDI (04h) clears the write-enable latch when select rises directly after its eighth bit.
- R7: WRITE (02h), a 16-bit address and one or more data bytes commit when select rises, but only if the latch was set before that select period. A trailing partial byte is dropped. Bytes beyond the end of a PAGE_BYTES page wrap to the start of the same page.
- R8: A committed WRITE or WRSR clears the write-enable latch and holds busy for BUSY_CYC system clock cycles.
- R9: While busy, every opcode except RDSR is ignored until select rises.
- R10: WRSR (01h) followed by a full data byte loads bp from data bits 3:2 when select rises, if the latch was set.
- R11: Protect level 0 guards nothing, 1 the upper quarter, 2 the upper half and 3 the whole array. Bytes of a committed write that fall in the guarded range leave the array unchanged.
- R12: Mode 0 (clock idles low) and mode 3 (clock idles high) transfers give the same results.
- R13: An unknown opcode does not drive serial out and has no effect until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial-out pad driver |

## Verification
Each pin reaches the logic two system cycles late, and serial out is registered one cycle after the synchronized falling edge. A data bit is therefore valid about three system cycles after the serial clock falls. The bench drives a half serial period of five system cycles and samples serial out just before the next rising edge, which leaves margin in both modes. Status and array effects of a select release settle within four system cycles, and the bench waits twelve before it starts the next transfer. Busy is watched by polling RDSR rather than by counting cycles.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_RDATA, PH_STAT, PH_WDATA, PH_SRDATA, PH_WAIT
  } phase_e;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
endpackage

// File: rtl/eep_sync.sv
`timescale 1ns/1ps
module eep_sync #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/eep_array.sv
`timescale 1ns/1ps
module eep_array #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned PG_W   = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [7:0]             rd_byte_o,
  input  logic                   wb_we_i,
  input  logic [PG_W-1:0]        wb_idx_i,
  input  logic [7:0]             wb_data_i,
  input  logic                   wb_clr_i,
  input  logic                   commit_i,
  input  logic [ADDR_W-PG_W-1:0] commit_page_i,
  input  logic [1:0]             bp_i
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned PAGE  = 1 << PG_W;

  logic [7:0]      mem_q  [DEPTH];
  logic [7:0]      pbuf_q [PAGE];
  logic [PAGE-1:0] pval_q;

  function automatic logic is_prot(input logic [ADDR_W-1:0] a, input logic [1:0] lvl);
    unique case (lvl)
      2'd0:    is_prot = 1'b0;
      2'd1:    is_prot = a[ADDR_W-1] & a[ADDR_W-2];
      2'd2:    is_prot = a[ADDR_W-1];
      default: is_prot = 1'b1;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      for (int unsigned i = 0; i < PAGE; i++) pbuf_q[i] <= 8'h00;
      pval_q <= '0;
    end else begin
      if (wb_we_i) begin
        pbuf_q[wb_idx_i] <= wb_data_i;
        pval_q[wb_idx_i] <= 1'b1;
      end
      if (commit_i) begin
        for (int unsigned i = 0; i < PAGE; i++) begin
          if (pval_q[i] && !is_prot({commit_page_i, PG_W'(i)}, bp_i))
            mem_q[{commit_page_i, PG_W'(i)}] <= pbuf_q[i];
        end
      end
      if (wb_clr_i) pval_q <= '0;
    end
  end

  assign rd_byte_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eep_spi_fsm.sv
`timescale 1ns/1ps
module eep_spi_fsm
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned PG_W     = 5,
  parameter int unsigned BUSY_CYC = 1000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_act_i,
  input  logic                   cs_rise_i,
  input  logic                   sck_rise_i,
  input  logic                   sck_fall_i,
  input  logic                   si_i,
  input  logic [7:0]             rd_byte_i,
  output logic [ADDR_W-1:0]      rd_addr_o,
  output logic                   wb_we_o,
  output logic [PG_W-1:0]        wb_idx_o,
  output logic [7:0]             wb_data_o,
  output logic                   wb_clr_o,
  output logic                   commit_o,
  output logic [ADDR_W-PG_W-1:0] commit_page_o,
  output logic                   so_o,
  output logic                   so_oe_o,
  output logic                   busy_o,
  output logic                   wel_o,
  output logic [1:0]             bp_o
);
  localparam int unsigned BC_W = $clog2(BUSY_CYC + 1);

  phase_e                   phase_q;
  logic [2:0]               bcnt_q;
  logic [3:0]               acnt_q;
  logic [6:0]               sh_q;
  logic [ADDR_W-2:0]        a_sh_q;
  logic                     is_rd_q;
  logic [ADDR_W-1:0]        ptr_q;
  logic [ADDR_W-PG_W-1:0]   wr_page_q;
  logic [PG_W-1:0]          wr_idx_q;
  logic                     wr_any_q, sr_full_q, wren_pend_q, wrdi_pend_q;
  logic [1:0]               sr_bp_q, bp_q;
  logic                     wel_q, so_q, oe_q;
  logic [BC_W-1:0]          busy_cnt_q;
  logic                     wb_we_q, commit_q, clr_q;
  logic [PG_W-1:0]          wb_idx_q;
  logic [7:0]               wb_data_q;

  logic                     busy;
  logic [7:0]               nxt, status;
  logic [ADDR_W-1:0]        nxt_a;

  assign busy   = (busy_cnt_q != '0);
  assign nxt    = {sh_q, si_i};
  assign nxt_a  = {a_sh_q, si_i};
  assign status = {4'b0000, bp_q, wel_q, busy};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;  bcnt_q <= '0;  acnt_q <= '0;  sh_q <= '0;  a_sh_q <= '0;
      is_rd_q <= 1'b0;    ptr_q <= '0;   wr_page_q <= '0;  wr_idx_q <= '0;
      wr_any_q <= 1'b0;   sr_full_q <= 1'b0;  sr_bp_q <= '0;
      wren_pend_q <= 1'b0;  wrdi_pend_q <= 1'b0;
      wel_q <= 1'b0;  bp_q <= '0;  busy_cnt_q <= '0;  so_q <= 1'b0;  oe_q <= 1'b0;
      wb_we_q <= 1'b0;  wb_idx_q <= '0;  wb_data_q <= '0;  commit_q <= 1'b0;  clr_q <= 1'b0;
    end else begin
      wb_we_q  <= 1'b0;
      commit_q <= 1'b0;
      clr_q    <= 1'b0;
      if (busy) busy_cnt_q <= busy_cnt_q - 1'b1;
      if (cs_rise_i) begin
        phase_q <= PH_CMD;  bcnt_q <= '0;  acnt_q <= '0;  oe_q <= 1'b0;
        wren_pend_q <= 1'b0;  wrdi_pend_q <= 1'b0;  wr_any_q <= 1'b0;  sr_full_q <= 1'b0;
        clr_q <= 1'b1;
        if (!busy) begin
          if (wren_pend_q) wel_q <= 1'b1;
          if (wrdi_pend_q) wel_q <= 1'b0;
          if ((wr_any_q || sr_full_q) && wel_q) begin
            wel_q      <= 1'b0;
            busy_cnt_q <= BC_W'(BUSY_CYC);
            commit_q   <= wr_any_q;
            if (sr_full_q) bp_q <= sr_bp_q;
          end
        end
      end else if (!cs_act_i) begin
        phase_q <= PH_CMD;  bcnt_q <= '0;  acnt_q <= '0;  oe_q <= 1'b0;
      end else if (sck_rise_i) begin
        unique case (phase_q)
          PH_CMD: begin
            sh_q   <= nxt[6:0];
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == 3'd7) begin
              if (busy && nxt != OP_RDSR) phase_q <= PH_WAIT;
              else begin
                case (nxt)
                  OP_WREN:  begin wren_pend_q <= 1'b1; phase_q <= PH_WAIT; end
                  OP_WRDI:  begin wrdi_pend_q <= 1'b1; phase_q <= PH_WAIT; end
                  OP_RDSR:  phase_q <= PH_STAT;
                  OP_WRSR:  phase_q <= PH_SRDATA;
                  OP_READ:  begin is_rd_q <= 1'b1; phase_q <= PH_ADDR; end
                  OP_WRITE: begin is_rd_q <= 1'b0; phase_q <= PH_ADDR; end
                  default:  phase_q <= PH_WAIT;
                endcase
              end
            end
          end
          PH_ADDR: begin
            a_sh_q <= nxt_a[ADDR_W-2:0];
            acnt_q <= acnt_q + 1'b1;
            if (acnt_q == 4'd15) begin
              bcnt_q <= '0;
              if (is_rd_q) begin
                ptr_q   <= nxt_a;
                phase_q <= PH_RDATA;
              end else begin
                wr_page_q <= nxt_a[ADDR_W-1:PG_W];
                wr_idx_q  <= nxt_a[PG_W-1:0];
                phase_q   <= PH_WDATA;
              end
            end
          end
          PH_RDATA: begin
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == 3'd7) ptr_q <= ptr_q + 1'b1;
          end
          PH_STAT: bcnt_q <= bcnt_q + 1'b1;
          PH_WDATA: begin
            sh_q   <= nxt[6:0];
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == 3'd7) begin
              wb_we_q   <= 1'b1;
              wb_idx_q  <= wr_idx_q;
              wb_data_q <= nxt;
              wr_idx_q  <= wr_idx_q + 1'b1;
              wr_any_q  <= 1'b1;
            end
          end
          PH_SRDATA: begin
            sh_q   <= nxt[6:0];
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == 3'd7) begin
              sr_full_q <= 1'b1;
              sr_bp_q   <= nxt[3:2];
              phase_q   <= PH_WAIT;
            end
          end
          default: begin
            wren_pend_q <= 1'b0;
            wrdi_pend_q <= 1'b0;
          end
        endcase
      end else if (sck_fall_i) begin
        if (phase_q == PH_RDATA) begin
          so_q <= rd_byte_i[3'd7 - bcnt_q];
          oe_q <= 1'b1;
        end else if (phase_q == PH_STAT) begin
          so_q <= status[3'd7 - bcnt_q];
          oe_q <= 1'b1;
        end
      end
    end
  end

  assign rd_addr_o     = ptr_q;
  assign wb_we_o       = wb_we_q;
  assign wb_idx_o      = wb_idx_q;
  assign wb_data_o     = wb_data_q;
  assign wb_clr_o      = clr_q;
  assign commit_o      = commit_q;
  assign commit_page_o = wr_page_q;
  assign so_o          = so_q;
  assign so_oe_o       = oe_q;
  assign busy_o        = busy;
  assign wel_o         = wel_q;
  assign bp_o          = bp_q;
endmodule

// File: rtl/eep_spi_slave.sv
`timescale 1ns/1ps
module eep_spi_slave #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned BUSY_CYC   = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int unsigned PG_W = $clog2(PAGE_BYTES);
  localparam int unsigned PN_W = ADDR_W - PG_W;

  logic [2:0]        pin_s;
  logic              cs_q, sck_q;
  logic              cs_act, cs_rise, sck_rise, sck_fall;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_byte, wb_data;
  logic              wb_we, wb_clr, arr_commit;
  logic [PG_W-1:0]   wb_idx;
  logic [PN_W-1:0]   commit_page;
  logic              st_busy, st_wel;
  logic [1:0]        st_bp;

  eep_sync #(.N(3), .RST_VAL(3'b100)) sync_i (
    .clk_i, .rst_ni, .d_i({cs_ni, sck_i, si_i}), .q_o(pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= pin_s[2];
      sck_q <= pin_s[1];
    end
  end

  assign cs_act   = ~pin_s[2];
  assign cs_rise  = pin_s[2] & ~cs_q;
  assign sck_rise = pin_s[1] & ~sck_q;
  assign sck_fall = ~pin_s[1] & sck_q;

  eep_spi_fsm #(.ADDR_W(ADDR_W), .PG_W(PG_W), .BUSY_CYC(BUSY_CYC)) fsm_i (
    .clk_i, .rst_ni,
    .cs_act_i(cs_act), .cs_rise_i(cs_rise), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .si_i(pin_s[0]), .rd_byte_i(rd_byte), .rd_addr_o(rd_addr),
    .wb_we_o(wb_we), .wb_idx_o(wb_idx), .wb_data_o(wb_data), .wb_clr_o(wb_clr),
    .commit_o(arr_commit), .commit_page_o(commit_page),
    .so_o, .so_oe_o, .busy_o(st_busy), .wel_o(st_wel), .bp_o(st_bp)
  );

  eep_array #(.ADDR_W(ADDR_W), .PG_W(PG_W)) array_i (
    .clk_i, .rst_ni, .rd_addr_i(rd_addr), .rd_byte_o(rd_byte),
    .wb_we_i(wb_we), .wb_idx_i(wb_idx), .wb_data_i(wb_data), .wb_clr_i(wb_clr),
    .commit_i(arr_commit), .commit_page_i(commit_page), .bp_i(st_bp)
  );
endmodule

// File: rtl/eep_spi_slave_chk.sv
`timescale 1ns/1ps
module eep_spi_slave_chk #(
  parameter int unsigned BUSY_CYC = 1000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       so_oe_o,
  input logic       busy_i,
  input logic       wel_i,
  input logic [1:0] bp_i,
  input logic       commit_i
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (busy_i) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  a_r3_oe_off_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !so_oe_o);

  a_r8_wel_clear_at_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !wel_i);

  a_r8_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (run_q < CW'(BUSY_CYC)));

  a_r5_wel_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_i) |-> $past(cs_ni, 2));

  a_r9_commit_opens_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $rose(busy_i));

  a_r10_bp_moves_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bp_i) |-> $rose(busy_i));
endmodule

bind eep_spi_slave eep_spi_slave_chk #(.BUSY_CYC(BUSY_CYC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .so_oe_o(so_oe_o),
  .busy_i(st_busy), .wel_i(st_wel), .bp_i(st_bp), .commit_i(arr_commit)
);

// File: tb/eep_spi_slave_tb_top.sv
`timescale 1ns/1ps
module eep_spi_slave_tb_top;
  localparam int DEPTH = 512;
  localparam int PB    = 32;
  localparam int HALF  = 25;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] mem_m [DEPTH];
  logic [7:0] wbuf  [PB];
  logic       wel_m = 1'b0;
  logic [1:0] bp_m  = 2'd0;
  logic       cpol  = 1'b0;

  always #2.5 clk = ~clk;

  eep_spi_slave #(.ADDR_W(9), .PAGE_BYTES(PB), .BUSY_CYC(1000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic bit prot_m(input int a);
    case (bp_m)
      2'd0:    return 1'b0;
      2'd1:    return a >= 384;
      2'd2:    return a >= 256;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nb; i++) begin
      sck = 1'b0;
      si  = tx[7-i];
      #HALF;
      rx  = {rx[6:0], so};
      sck = 1'b1;
      #HALF;
    end
  endtask

  task automatic set_mode(input logic pol);
    cpol = pol;
    sck  = pol;
    #30;
  endtask

  task automatic cs_start();
    cs_n = 1'b0;
    #30;
  endtask

  task automatic cs_end();
    sck = cpol;
    #30;
    cs_n = 1'b1;
    #60;
  endtask

  task automatic op_only(input logic [7:0] op);
    logic [7:0] d;
    cs_start();
    xfer(op, 8, d);
    cs_end();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_start();
    xfer(8'h05, 8, d);
    xfer(8'h00, 8, s);
    cs_end();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'h01;
    for (int k = 0; k < 40 && s[0]; k++) rdsr(s);
    chk("R8 busy ends", 32'(s[0]), 32'd0);
  endtask

  task automatic do_wren();
    op_only(8'h06);
    wel_m = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] addr, input int n);
    logic [7:0] d, s;
    cs_start();
    xfer(8'h02, 8, d);
    xfer(addr[15:8], 8, d);
    xfer(addr[7:0], 8, d);
    for (int i = 0; i < n; i++) xfer(wbuf[i], 8, d);
    cs_end();
    if (wel_m) begin
      for (int i = 0; i < n; i++) begin
        int a;
        a = (int'(addr[8:0]) & ~(PB - 1)) | ((int'(addr[4:0]) + i) % PB);
        if (!prot_m(a)) mem_m[a] = wbuf[i];
      end
      wel_m = 1'b0;
      rdsr(s);
      chk("R8 commit sets busy, clears wel (R4 status)", 32'(s), 32'({4'b0, bp_m, 2'b01}));
      wait_idle();
    end else begin
      rdsr(s);
      chk("R7 no commit without wel", 32'(s), 32'({4'b0, bp_m, 2'b00}));
    end
  endtask

  task automatic do_wrsr(input logic [1:0] lvl);
    logic [7:0] d, s;
    cs_start();
    xfer(8'h01, 8, d);
    xfer({4'b0, lvl, 2'b00}, 8, d);
    cs_end();
    bp_m  = lvl;
    wel_m = 1'b0;
    wait_idle();
    rdsr(s);
    chk("R10 protect level loaded", 32'(s), 32'({4'b0, lvl, 2'b00}));
  endtask

  task automatic read_chk(input logic [15:0] addr, input int n, input string req);
    logic [7:0] d;
    cs_start();
    xfer(8'h03, 8, d);
    xfer(addr[15:8], 8, d);
    xfer(addr[7:0], 8, d);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, d);
      chk(req, 32'(d), 32'(mem_m[(int'(addr[8:0]) + i) % DEPTH]));
      if (i == 0) chk("R3 output enabled during read data", 32'(so_oe), 32'd1);
    end
    cs_end();
    chk("R3 output disabled after deselect", 32'(so_oe), 32'd0);
  endtask

  initial begin
    logic [7:0] s, s2, d;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    #23 rst_n = 1'b1;
    #50;

    chk("R1 serial out disabled after reset", 32'(so_oe), 32'd0);
    rdsr(s);
    chk("R1 status zero after reset", 32'(s), 32'h00);
    read_chk(16'h0000, 4, "R1 array erased after reset");

    wbuf[0] = 8'h5A;
    do_write(16'h0005, 1);
    read_chk(16'h0005, 1, "R7 write without latch ignored");

    do_wren();
    rdsr(s);
    chk("R5 latch set by WREN", 32'(s), 32'h02);
    cs_start(); xfer(8'h05, 8, d); xfer(8'h00, 8, s); xfer(8'h00, 8, s2); cs_end();
    chk("R4 status repeats on second byte", 32'(s2), 32'(s));
    op_only(8'h04);
    wel_m = 1'b0;
    rdsr(s);
    chk("R6 latch cleared by WRDI", 32'(s), 32'h00);

    cs_start();
    xfer(8'h06, 8, d); xfer(8'h02, 8, d); xfer(8'h00, 8, d); xfer(8'h05, 8, d); xfer(8'hA5, 8, d);
    cs_end();
    rdsr(s);
    chk("R5 WREN with extra clocks leaves latch clear", 32'(s), 32'h00);
    read_chk(16'h0005, 1, "R5 same-select write leaves array");

    for (int p = 0; p < DEPTH / PB; p++) begin
      set_mode(p[0]);
      do_wren();
      for (int i = 0; i < PB; i++) wbuf[i] = pat(p * PB + i);
      do_write(16'(p * PB), PB);
    end
    set_mode(1'b0);

    do_wren();
    cs_start(); xfer(8'h02, 8, d); xfer(8'h01, 8, d); xfer(8'hF0, 8, d); xfer(8'h11, 8, d); cs_end();
    mem_m[9'h1F0] = 8'h11;
    wel_m = 1'b0;
    cs_start(); xfer(8'h03, 8, d); xfer(8'h00, 8, d); xfer(8'h00, 8, d); xfer(8'h00, 8, d);
    chk("R9 READ ignored while busy", 32'(so_oe), 32'd0);
    cs_end();
    op_only(8'h06);
    rdsr(s);
    chk("R9 busy status during write (R4)", 32'(s), 32'h01);
    wait_idle();
    rdsr(s);
    chk("R9 WREN ignored while busy", 32'(s), 32'h00);

    read_chk(16'hFFE0, DEPTH + 32, "R2 sequential read with wrap");
    set_mode(1'b1);
    read_chk(16'hE0A3, 40, "R12 mode 3 read");
    set_mode(1'b0);

    do_wren(); do_wrsr(2'd1);
    do_wren(); wbuf[0] = 8'h5A; wbuf[1] = 8'h5B; do_write(16'h0180, 2);
    do_wren(); wbuf[0] = 8'hC3; do_write(16'h017F, 1);
    read_chk(16'h017E, 5, "R11 upper quarter guarded");
    do_wren(); do_wrsr(2'd2);
    do_wren(); wbuf[0] = 8'h77; do_write(16'h0100, 1);
    do_wren(); do_write(16'h00FF, 1);
    read_chk(16'h00FE, 4, "R11 upper half guarded");
    do_wren(); do_wrsr(2'd3);
    do_wren(); wbuf[0] = 8'h00; do_write(16'h0000, 1);
    read_chk(16'h0000, 2, "R11 whole array guarded");
    do_wren(); do_wrsr(2'd0);

    do_wren();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
    do_write(16'h001E, 4);
    read_chk(16'h0000, PB, "R7 page wrap");

    do_wren();
    cs_start(); xfer(8'h02, 8, d); xfer(8'h00, 8, d); xfer(8'h40, 8, d); xfer(8'h99, 4, d); cs_end();
    rdsr(s);
    chk("R7 partial byte not committed", 32'(s), 32'h02);
    read_chk(16'h0040, 1, "R7 partial byte leaves array");

    cs_start(); xfer(8'hAB, 8, d); xfer(8'h00, 8, d);
    chk("R13 unknown opcode keeps output off", 32'(so_oe), 32'd0);
    cs_end();
    rdsr(s);
    chk("R13 unknown opcode keeps status", 32'(s), 32'h02);

    op_only(8'h04);
    wel_m = 1'b0;
    rdsr(s);
    chk("R6 WRDI clears latch", 32'(s), 32'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #975000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule